// File: doc/BRIEF.md
# Three-Wire Synthesiser Control Port

This block is the digital control front end of a frequency synthesiser. A host sends a 28-bit programming word over three lines: serial data, serial clock and a frame enable. The serial lines come from another clock domain. Each line passes through a two-flop synchroniser into the system clock domain, and their edges are detected there. Bits are shifted in only while enable is high. When enable falls, the captured word moves into the control registers, but only if exactly 28 clock pulses arrived in that frame. Any other count discards the word and leaves the previous settings in place.

The block decodes the stored word into the settings the analog parts of the synthesiser need:
- the 17-bit programmable divider ratio;
- the reference divider select code and the division ratio that code picks;
- the charge-pump current code and its nominal current in microamps;
- a charge-pump mode;
- four open-drain port enables.

A test bit changes the meaning of the two lowest port bits. They then select either a forced charge-pump state or a monitor mode. In monitor mode, port 1 carries the comparison clock and port 0 carries the divider output divided by two.

The serial port is a plain control interface. It has no valid/ready handshake and applies no back-pressure. The host paces the bits itself, and every properly framed word is taken. All outputs are plain control levels that stay constant between loads.

Top module: `synth_ctrl_port`

## Requirements
- R1: After reset, the outputs are as follows: divider ratio 0, select code 0 with reference ratio 2, current code 0 with 230 µA, charge-pump mode normal (0), and all four port enables 0 (released, high impedance).
- R2: The word is sent MSB first. Bit 27 down to bit 24 are port bits P3 to P0. Bit 23 is the test bit. Bits 22:21 are the current code. Bits 20:18 are the reference select S2..S0. Bit 17 is the reference mode bit. Bits 16:0 are the divider ratio. The select code output is {mode bit, S2..S0}.
- R3: Serial clock pulses that arrive while enable is low have no effect on the shift register or on later loads.
- R4: If enable falls after any pulse count other than 28 (for example 27 or 29), the word is discarded and all outputs keep their previous values.
- R5: The current output decodes the current code as follows: 00 = 230, 01 = 1000, 10 = 115, 11 = 500 µA.
- R6: The reference ratio depends on the mode bit. With mode bit 0, the ratio is 2 << S. With mode bit 1, S=0 gives 3, and S>0 gives 5 << (S-1).
- R7: With the test bit 0, the charge-pump mode is normal (0). With the test bit 1, P1P0 selects the mode: 00 gives sink (1), 01 gives source (2), 10 gives off (3), and 11 gives normal. In the 00, 01 and 10 cases, port enables 1 and 0 are held at 0.
- R8: In monitor mode (test bit 1, P1P0=11), port enable 1 follows `fcomp_in` with no register delay. Port enable 0 is a flop that toggles on every clock cycle in which `fpd_in` is high, and it is 0 after reset.
- R9: Outside test mode, each port enable equals its port bit, where 1 means the port is sinking. P3 and P2 always follow their bits.
- R10: The outputs do not change while a frame is open, even after all 28 bits have been shifted. They update only after enable falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data | input | 1 | Serial data, sampled on serial clock rise |
| ser_clk | input | 1 | Serial bit clock |
| ser_en | input | 1 | Frame enable; the falling edge loads the word |
| fcomp_in | input | 1 | Comparison clock, used as a monitor source |
| fpd_in | input | 1 | One-cycle strobe per divider output cycle |
| div_ratio | output | 17 | Programmable divider ratio |
| ref_code | output | 4 | Reference divider select {mode, S2..S0} |
| ref_ratio | output | 9 | Decoded reference division ratio |
| cp_code | output | 2 | Charge-pump current code |
| cp_ua | output | 10 | Nominal charge-pump current, in µA |
| cp_mode | output | 2 | 0 normal, 1 sink, 2 source, 3 off |
| port_sink | output | 4 | Port driver enables, 1 = sinking |

## Verification
Each serial line change reaches the edge detector after two synchroniser flops. The change takes effect on the third rising clock edge after it is applied, so the decoded outputs settle by that edge after enable falls. The bench holds each serial phase for four clock cycles and waits eight cycles after the enable fall before it samples on a falling edge. The `fcomp_in` path is combinational and is checked one time step after it changes. The `fpd_in` toggle is checked on the falling edge after the rising edge that registers the strobe.

// File: rtl/synth_ctrl_pkg.sv
package synth_ctrl_pkg;
  localparam int WORD_W = 28;
  localparam int DIV_W  = 17;

  typedef enum logic [1:0] {
    CP_NORMAL = 2'd0,
    CP_SINK   = 2'd1,
    CP_SOURCE = 2'd2,
    CP_OFF    = 2'd3
  } cp_mode_e;

  typedef struct packed {
    logic [3:0]       port;
    logic             test;
    logic [1:0]       cp;
    logic [2:0]       rsel;
    logic             rmode;
    logic [DIV_W-1:0] div;
  } ctrl_word_t;

  function automatic logic [8:0] ref_ratio_f(input logic rmode, input logic [2:0] rsel);
    logic [8:0] r;
    if (!rmode)          r = 9'd2 << rsel;
    else if (rsel == 0)  r = 9'd3;
    else                 r = 9'd5 << (rsel - 3'd1);
    return r;
  endfunction

  function automatic logic [9:0] cp_ua_f(input logic [1:0] code);
    logic [9:0] u;
    case (code)
      2'b00:   u = 10'd230;
      2'b01:   u = 10'd1000;
      2'b10:   u = 10'd115;
      default: u = 10'd500;
    endcase
    return u;
  endfunction
endpackage

// File: rtl/sync_bits.sv
module sync_bits #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ser_shift.sv
module ser_shift #(
  parameter int WORD_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sd,
  input  logic              sc,
  input  logic              se,
  output logic              load,
  output logic [WORD_W-1:0] word
);
  localparam int CNT_MAX = WORD_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             sc_q, se_q;
  logic [CNT_W-1:0] cnt;
  logic             sc_rise, se_rise, se_fall;

  assign sc_rise = sc & ~sc_q;
  assign se_rise = se & ~se_q;
  assign se_fall = ~se & se_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q <= 1'b0;
      se_q <= 1'b0;
      cnt  <= '0;
      word <= '0;
    end else begin
      sc_q <= sc;
      se_q <= se;
      if (se_rise) begin
        cnt <= '0;
      end else if (se && sc_rise) begin
        word <= {word[WORD_W-2:0], sd};
        if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
      end
    end
  end

  assign load = se_fall && (cnt == CNT_W'(WORD_W));
endmodule

// File: rtl/ctrl_regs.sv
module ctrl_regs
  import synth_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WORD_W-1:0] word,
  output ctrl_word_t       cfg,
  output logic [DIV_W-1:0] div_ratio,
  output logic [3:0]       ref_code,
  output logic [8:0]       ref_ratio,
  output logic [1:0]       cp_code,
  output logic [9:0]       cp_ua
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg <= '0;
    else if (load) cfg <= ctrl_word_t'(word);
  end

  assign div_ratio = cfg.div;
  assign ref_code  = {cfg.rmode, cfg.rsel};
  assign ref_ratio = ref_ratio_f(cfg.rmode, cfg.rsel);
  assign cp_code   = cfg.cp;
  assign cp_ua     = cp_ua_f(cfg.cp);
endmodule

// File: rtl/port_mux.sv
module port_mux
  import synth_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] port_bits,
  input  logic       test,
  input  logic       fcomp_in,
  input  logic       fpd_in,
  output logic [1:0] cp_mode,
  output logic [3:0] port_sink
);
  logic     fpd_half;
  cp_mode_e mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fpd_half <= 1'b0;
    else if (fpd_in) fpd_half <= ~fpd_half;
  end

  always_comb begin
    mode      = CP_NORMAL;
    port_sink = port_bits;
    if (test) begin
      case (port_bits[1:0])
        2'b00:   begin mode = CP_SINK;   port_sink[1:0] = 2'b00; end
        2'b01:   begin mode = CP_SOURCE; port_sink[1:0] = 2'b00; end
        2'b10:   begin mode = CP_OFF;    port_sink[1:0] = 2'b00; end
        default: begin
          mode         = CP_NORMAL;
          port_sink[1] = fcomp_in;
          port_sink[0] = fpd_half;
        end
      endcase
    end
  end

  assign cp_mode = mode;
endmodule

// File: rtl/synth_ctrl_port.sv
module synth_ctrl_port
  import synth_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_data,
  input  logic             ser_clk,
  input  logic             ser_en,
  input  logic             fcomp_in,
  input  logic             fpd_in,
  output logic [DIV_W-1:0] div_ratio,
  output logic [3:0]       ref_code,
  output logic [8:0]       ref_ratio,
  output logic [1:0]       cp_code,
  output logic [9:0]       cp_ua,
  output logic [1:0]       cp_mode,
  output logic [3:0]       port_sink
);
  logic [2:0]        ser_s;
  logic              load_stb;
  logic [WORD_W-1:0] shift_word;
  ctrl_word_t        cfg;

  sync_bits #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ser_data, ser_clk, ser_en}), .q(ser_s)
  );

  ser_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .sd(ser_s[2]), .sc(ser_s[1]), .se(ser_s[0]),
    .load(load_stb), .word(shift_word)
  );

  ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .load(load_stb), .word(shift_word),
    .cfg(cfg), .div_ratio(div_ratio), .ref_code(ref_code),
    .ref_ratio(ref_ratio), .cp_code(cp_code), .cp_ua(cp_ua)
  );

  port_mux u_mux (
    .clk(clk), .rst_n(rst_n), .port_bits(cfg.port), .test(cfg.test),
    .fcomp_in(fcomp_in), .fpd_in(fpd_in),
    .cp_mode(cp_mode), .port_sink(port_sink)
  );
endmodule

// File: rtl/synth_ctrl_chk.sv
module synth_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ser_en,
  input logic        load,
  input logic [16:0] div_ratio,
  input logic [9:0]  cp_ua,
  input logic [1:0]  cp_mode,
  input logic [3:0]  port_sink
);
  // R10
  hold_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(div_ratio));

  // R9
  hold_high_ports_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(port_sink[3:2]));

  // R4
  load_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> ($past(ser_en, 3) && !$past(ser_en, 2)));

  // R5
  legal_current_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_ua == 10'd230) || (cp_ua == 10'd1000) || (cp_ua == 10'd115) || (cp_ua == 10'd500));

  // R7
  forced_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_mode != 2'd0) |-> (port_sink[1:0] == 2'b00));
endmodule

bind synth_ctrl_port synth_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .load(load_stb),
  .div_ratio(div_ratio), .cp_ua(cp_ua), .cp_mode(cp_mode), .port_sink(port_sink)
);

// File: tb/sim_synth_ctrl_port.sv
`timescale 1ns/1ps
module sim_synth_ctrl_port;
  logic clk = 0, rst_n = 0;
  logic ser_data = 0, ser_clk = 0, ser_en = 0, fcomp_in = 0, fpd_in = 0;
  logic [16:0] div_ratio;
  logic [3:0]  ref_code;
  logic [8:0]  ref_ratio;
  logic [1:0]  cp_code;
  logic [9:0]  cp_ua;
  logic [1:0]  cp_mode;
  logic [3:0]  port_sink;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  synth_ctrl_port u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [27:0] mk(input logic [3:0] p, input logic t, input logic [1:0] c,
                                     input logic rm, input logic [2:0] rs, input logic [16:0] d);
    return {p, t, c, rs, rm, d};
  endfunction

  task automatic shift_bits(input logic [27:0] w, input int n);
    ser_en = 1;
    wait_n(4);
    for (int i = 0; i < n; i++) begin
      ser_data = (i < 28) ? w[27-i] : 1'b0;
      wait_n(4);
      ser_clk = 1;
      wait_n(4);
      ser_clk = 0;
    end
    wait_n(4);
  endtask

  task automatic close_frame;
    ser_en = 0;
    wait_n(8);
  endtask

  task automatic send(input logic [27:0] w, input int n);
    shift_bits(w, n);
    close_frame();
  endtask

  function automatic int exp_ratio(input logic rm, input logic [2:0] rs);
    if (!rm) return 2 << rs;
    if (rs == 0) return 3;
    return 5 << (rs - 1);
  endfunction

  function automatic int exp_ua(input logic [1:0] c);
    case (c)
      2'd0: return 230;
      2'd1: return 1000;
      2'd2: return 115;
      default: return 500;
    endcase
  endfunction

  initial begin
    int half;
    wait_n(3);
    rst_n = 1;
    wait_n(2);
    // R1 reset state
    chk("R1 div", div_ratio, 0);
    chk("R1 ports", port_sink, 0);
    chk("R1 mode", cp_mode, 0);
    chk("R1 ua", cp_ua, 230);
    chk("R1 ratio", ref_ratio, 2);

    // R2 field placement, several divider patterns
    send(mk(4'b1010, 0, 2'b01, 1, 3'd5, 17'h1ABCD), 28);
    chk("R2 div", div_ratio, 'h1ABCD);
    chk("R2 ref_code", ref_code, 4'b1101);
    chk("R2 cp_code", cp_code, 1);
    chk("R2 ports", port_sink, 4'b1010);
    send(mk(4'b0101, 0, 2'b10, 0, 3'd2, 17'h00001), 28);
    chk("R2 div", div_ratio, 1);
    chk("R2 ref_code", ref_code, 4'b0010);
    send(mk(4'b0000, 0, 2'b00, 0, 3'd0, 17'h1FFFF), 28);
    chk("R2 div", div_ratio, 'h1FFFF);

    // R4 wrong counts discarded
    send(mk(4'b1111, 0, 2'b11, 1, 3'd7, 17'h05555), 27);
    chk("R4 short div", div_ratio, 'h1FFFF);
    chk("R4 short ports", port_sink, 0);
    send(mk(4'b1111, 0, 2'b11, 1, 3'd7, 17'h05555), 29);
    chk("R4 long div", div_ratio, 'h1FFFF);
    chk("R4 long ua", cp_ua, 230);

    // R3 pulses while enable low are ignored
    for (int i = 0; i < 5; i++) begin
      ser_data = 1; wait_n(4); ser_clk = 1; wait_n(4); ser_clk = 0; wait_n(4);
    end
    chk("R3 idle pulses", div_ratio, 'h1FFFF);
    send(mk(4'b0000, 0, 2'b00, 0, 3'd0, 17'h00F0F), 28);
    chk("R3 next word", div_ratio, 'h00F0F);

    // R10 no update while frame open
    shift_bits(mk(4'b1100, 0, 2'b00, 0, 3'd0, 17'h12345), 28);
    chk("R10 open div", div_ratio, 'h00F0F);
    chk("R10 open ports", port_sink, 0);
    close_frame();
    chk("R10 closed div", div_ratio, 'h12345);

    // R6 all reference codes
    for (int k = 0; k < 16; k++) begin
      send(mk(4'b0000, 0, 2'b00, k[3], k[2:0], 17'd100), 28);
      chk("R6 ratio", ref_ratio, exp_ratio(k[3], k[2:0]));
    end

    // R5 all current codes
    for (int k = 0; k < 4; k++) begin
      send(mk(4'b0000, 0, k[1:0], 0, 3'd0, 17'd100), 28);
      chk("R5 ua", cp_ua, exp_ua(k[1:0]));
    end

    // R9 all port patterns, normal mode
    for (int k = 0; k < 16; k++) begin
      send(mk(k[3:0], 0, 2'b00, 0, 3'd0, 17'd100), 28);
      chk("R9 ports", port_sink, k);
      chk("R7 normal mode", cp_mode, 0);
    end

    // R7 forced test modes
    for (int k = 0; k < 3; k++) begin
      send(mk({2'b11, k[1:0]}, 1, 2'b00, 0, 3'd0, 17'd100), 28);
      chk("R7 mode", cp_mode, k + 1);
      chk("R7 ports", port_sink, 4'b1100);
    end

    // R8 monitor mode
    send(mk(4'b1011, 1, 2'b00, 0, 3'd0, 17'd100), 28);
    chk("R8 mode", cp_mode, 0);
    half = 0;
    for (int k = 0; k < 4; k++) begin
      fcomp_in = k[0]; #1;
      chk("R8 fcomp", port_sink[1], k[0]);
      chk("R9 P3 in monitor", port_sink[3], 1);
      fpd_in = 1; wait_n(1); fpd_in = 0; half ^= 1;
      chk("R8 fpd half", port_sink[0], half);
      wait_n(2);
      chk("R8 fpd hold", port_sink[0], half);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule